// File: doc/BRIEF.md
# Batch Mixer Sequence Controller

This block sequences a two-tank beverage mixing cell. A coordinating master state machine hands work to four subordinate state machines: one for the tanks, one for the trolley, and one for each of the two containers. The master raises a per-subordinate enable and waits for each subordinate's one-cycle done pulse. A subordinate that loses its enable drops to an idle state with its outputs low. When it is enabled again it starts from its first working step.

A start request launches two branches that run side by side. The tank branch fills both tanks, prepares both ingredients, then pours them into the mixing tank and runs the mixer. The trolley branch loads the containers and drives the trolley to the end of its travel. Once both branches report completion, the two containers are filled and closed independently of each other. The trolley is then driven home, and the home sensor returns the cell to its ready state.

Sensors arrive on one vector and actuator commands leave on another. Sensor xk sits on bit k-1 of `sens_i` and actuator yk on bit k-1 of `act_o`. All actuator outputs come straight from flops.

Top module: `mixer_ctrl`

## Requirements
- R1: While rst_ni is low, every bit of act_o is 0, and the controller is ready to accept a start.
- R2: In the ready state, x1 (sens_i[0]) starts a cycle. On the second rising edge after x1 is sampled, y3 (act_o[2]), y10 (act_o[9]) and y11 (act_o[10]) are high.
- R3: Inlet y10 drops on the edge that samples x5 (sens_i[4]), and inlet y11 drops on the edge that samples x7 (sens_i[6]); each inlet closes independently of the other. Preparation begins on the edge where both tanks have been seen full, including when x5 and x7 arrive in the same cycle.
- R4: y3 stays high until x4 (sens_i[3]) is sampled. On that edge y3 drops and trolley drive y12 (act_o[11]) rises, and y12 then stays high until x13 (sens_i[12]) is sampled. y3 and y12 are never high together.
- R5: Preparation outputs y1 (act_o[0]) and y2 (act_o[1]) rise together. y1 drops on x2 (sens_i[1]) and y2 drops on x3 (sens_i[2]), each on its own. Pouring starts once both ingredients have been seen ready.
- R6: Pouring raises y5 (act_o[4]), y6 (act_o[5]) and mixer y4 (act_o[3]) together. y5 drops on x6 (sens_i[5]), y6 drops on x8 (sens_i[7]) and y4 drops on x9 (sens_i[8]). The tank branch completes once all three have been seen.
- R7: Container fill outputs y7 (act_o[6]) and y8 (act_o[7]) rise only after both the tank branch and the trolley branch have completed. y7 drops on x10 (sens_i[9]) and y8 drops on x11 (sens_i[10]), each container on its own.
- R8: Return drive y9 (act_o[8]) rises on the edge where the last container completes. It stays high until x12 (sens_i[11]) is sampled, and the controller is then ready again.
- R9: x1 has no effect while a cycle is running. In the ready state, every sensor other than x1 has no effect.
- R10: A subordinate that is disabled sits idle with its outputs low. Its done pulse lasts one cycle. On re-enable it restarts from its first step and ignores, on that entry edge, sensors left over from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sens_i | input | 13 | Sensor inputs, bit k-1 carries xk, active high |
| act_o | output | 12 | Registered actuator commands, bit k-1 carries yk, active high |

## Verification
The bench builds the block with the package defaults: 13 sensors, 12 actuators and two container channels. This exposes both independent container completions and the interaction between the two concurrent first-phase branches. The table walks a full batch in which the trolley finishes long before the tanks, then starts a second batch. That second batch exposes restart from the first substate with stale full sensors still high. It also covers both tanks reporting full in the same cycle. Directed steps cover an asynchronous reset in mid-batch, and sensor activity in the ready state that must not start anything.

// File: rtl/mixer_pkg.sv
package mixer_pkg;
  localparam int SENS_W = 13;
  localparam int ACT_W  = 12;
  localparam int CONT_N = 2;

  // sensor bit positions (xk on bit k-1)
  localparam int S_START  = 0;
  localparam int S_RDY1   = 1;
  localparam int S_RDY2   = 2;
  localparam int S_SEATED = 3;
  localparam int S_FULL1  = 4;
  localparam int S_EMPTY1 = 5;
  localparam int S_FULL2  = 6;
  localparam int S_EMPTY2 = 7;
  localparam int S_MIXED  = 8;
  localparam int S_CDONE0 = 9;
  localparam int S_HOME   = 11;
  localparam int S_END    = 12;

  // actuator bit positions (yk on bit k-1)
  localparam int A_PREP1  = 0;
  localparam int A_PREP2  = 1;
  localparam int A_DELIV  = 2;
  localparam int A_MIX    = 3;
  localparam int A_POUR1  = 4;
  localparam int A_POUR2  = 5;
  localparam int A_CFILL0 = 6;
  localparam int A_RET    = 8;
  localparam int A_INLET1 = 9;
  localparam int A_INLET2 = 10;
  localparam int A_TROL   = 11;

  typedef enum logic [1:0] {M_READY, M_BRANCH, M_CONT, M_RETURN} master_st_e;
  typedef enum logic [2:0] {TK_IDLE, TK_FILL, TK_PREP, TK_POUR, TK_DONE, TK_PARK} tank_st_e;
  typedef enum logic [2:0] {TR_IDLE, TR_LOAD, TR_MOVE, TR_DONE, TR_PARK} trol_st_e;
  typedef enum logic [1:0] {CT_IDLE, CT_WORK, CT_DONE, CT_PARK} cont_st_e;
endpackage

// File: rtl/mixer_master.sv
module mixer_master
  import mixer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              home_i,
  input  logic              tank_done_i,
  input  logic              trol_done_i,
  input  logic [CONT_N-1:0] cont_done_i,
  output logic              branch_en_o,
  output logic              cont_en_o,
  output logic              ret_o
);
  master_st_e        state_q, state_d;
  logic [1:0]        br_seen_q, br_seen_d, br_now;
  logic [CONT_N-1:0] ct_seen_q, ct_seen_d, ct_now;

  always_comb begin
    state_d   = state_q;
    br_seen_d = br_seen_q;
    ct_seen_d = ct_seen_q;
    br_now    = br_seen_q | {trol_done_i, tank_done_i};
    ct_now    = ct_seen_q | cont_done_i;
    unique case (state_q)
      M_READY: begin
        br_seen_d = '0;
        ct_seen_d = '0;
        if (start_i) state_d = M_BRANCH;
      end
      M_BRANCH: begin
        br_seen_d = br_now;
        if (&br_now) begin
          state_d   = M_CONT;
          br_seen_d = '0;
        end
      end
      M_CONT: begin
        ct_seen_d = ct_now;
        if (&ct_now) begin
          state_d   = M_RETURN;
          ct_seen_d = '0;
        end
      end
      M_RETURN: if (home_i) state_d = M_READY;
      default:  state_d = M_READY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= M_READY;
      br_seen_q <= '0;
      ct_seen_q <= '0;
      ret_o     <= 1'b0;
    end else begin
      state_q   <= state_d;
      br_seen_q <= br_seen_d;
      ct_seen_q <= ct_seen_d;
      ret_o     <= (state_d == M_RETURN);
    end
  end

  assign branch_en_o = (state_q == M_BRANCH);
  assign cont_en_o   = (state_q == M_CONT);

  AST_START_ONLY_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != M_READY && state_q != M_BRANCH) |=> (state_q != M_BRANCH)); // R9
  AST_RETURN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == M_RETURN && !home_i) |=> ret_o); // R8
  AST_PHASE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(branch_en_o && cont_en_o)); // R7
endmodule

// File: rtl/mixer_tank_fsm.sv
module mixer_tank_fsm
  import mixer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] full_i,
  input  logic [1:0] ready_i,
  input  logic [1:0] empty_i,
  input  logic       mixed_i,
  output logic [1:0] inlet_o,
  output logic [1:0] prep_o,
  output logic [1:0] pour_o,
  output logic       mix_o,
  output logic       done_o
);
  tank_st_e   state_q, state_d;
  logic [2:0] seen_q, seen_d, seen_now;
  logic [1:0] inlet_d, prep_d, pour_d;
  logic       mix_d;

  always_comb begin
    state_d  = state_q;
    seen_d   = seen_q;
    seen_now = seen_q;
    if (!en_i) begin
      state_d = TK_IDLE;
      seen_d  = '0;
    end else begin
      unique case (state_q)
        TK_IDLE: begin
          state_d = TK_FILL;
          seen_d  = '0;
        end
        TK_FILL: begin
          seen_now = seen_q | {1'b0, full_i};
          seen_d   = seen_now;
          if (&seen_now[1:0]) begin
            state_d = TK_PREP;
            seen_d  = '0;
          end
        end
        TK_PREP: begin
          seen_now = seen_q | {1'b0, ready_i};
          seen_d   = seen_now;
          if (&seen_now[1:0]) begin
            state_d = TK_POUR;
            seen_d  = '0;
          end
        end
        TK_POUR: begin
          seen_now = seen_q | {mixed_i, empty_i};
          seen_d   = seen_now;
          if (&seen_now) begin
            state_d = TK_DONE;
            seen_d  = '0;
          end
        end
        TK_DONE: state_d = TK_PARK;
        TK_PARK: state_d = TK_PARK;
        default: state_d = TK_IDLE;
      endcase
    end
  end

  // outputs follow the next state so they leave flops with no extra cycle
  always_comb begin
    inlet_d = '0;
    prep_d  = '0;
    pour_d  = '0;
    mix_d   = 1'b0;
    unique case (state_d)
      TK_FILL: inlet_d = ~seen_d[1:0];
      TK_PREP: prep_d  = ~seen_d[1:0];
      TK_POUR: begin
        pour_d = ~seen_d[1:0];
        mix_d  = ~seen_d[2];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TK_IDLE;
      seen_q  <= '0;
      inlet_o <= '0;
      prep_o  <= '0;
      pour_o  <= '0;
      mix_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      seen_q  <= seen_d;
      inlet_o <= inlet_d;
      prep_o  <= prep_d;
      pour_o  <= pour_d;
      mix_o   <= mix_d;
    end
  end

  assign done_o = (state_q == TK_DONE);

  AST_INLET1_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TK_FILL && full_i[0]) |=> !inlet_o[0]); // R3
  AST_INLET2_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TK_FILL && full_i[1]) |=> !inlet_o[1]); // R3
  AST_MIX_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mix_o && mixed_i) |=> !mix_o); // R6
  AST_TANK_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_TANK_IDLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (inlet_o == '0 && prep_o == '0 && pour_o == '0 && !mix_o && !done_o)); // R10
endmodule

// File: rtl/mixer_trolley_fsm.sv
module mixer_trolley_fsm
  import mixer_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic seated_i,
  input  logic end_i,
  output logic deliv_o,
  output logic move_o,
  output logic done_o
);
  trol_st_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!en_i) state_d = TR_IDLE;
    else begin
      unique case (state_q)
        TR_IDLE: state_d = TR_LOAD;
        TR_LOAD: if (seated_i) state_d = TR_MOVE;
        TR_MOVE: if (end_i) state_d = TR_DONE;
        TR_DONE: state_d = TR_PARK;
        TR_PARK: state_d = TR_PARK;
        default: state_d = TR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TR_IDLE;
      deliv_o <= 1'b0;
      move_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      deliv_o <= (state_d == TR_LOAD);
      move_o  <= (state_d == TR_MOVE);
    end
  end

  assign done_o = (state_q == TR_DONE);

  AST_DELIV_MOVE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(deliv_o && move_o)); // R4
  AST_LOAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deliv_o && en_i && !seated_i) |=> deliv_o); // R4
  AST_TROL_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
endmodule

// File: rtl/mixer_cont_fsm.sv
module mixer_cont_fsm
  import mixer_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic finished_i,
  output logic fill_o,
  output logic done_o
);
  cont_st_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!en_i) state_d = CT_IDLE;
    else begin
      unique case (state_q)
        CT_IDLE: state_d = CT_WORK;
        CT_WORK: if (finished_i) state_d = CT_DONE;
        CT_DONE: state_d = CT_PARK;
        CT_PARK: state_d = CT_PARK;
        default: state_d = CT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CT_IDLE;
      fill_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      fill_o  <= (state_d == CT_WORK);
    end
  end

  assign done_o = (state_q == CT_DONE);

  AST_FILL_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_o && finished_i) |=> !fill_o); // R7
  AST_CONT_IDLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!fill_o && !done_o)); // R10
endmodule

// File: rtl/mixer_ctrl.sv
module mixer_ctrl
  import mixer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SENS_W-1:0] sens_i,
  output logic [ACT_W-1:0]  act_o
);
  logic              branch_en, cont_en, ret;
  logic              tank_done, trol_done;
  logic [CONT_N-1:0] cont_done, cont_fill;
  logic [1:0]        inlet, prep, pour;
  logic              mix, deliv, move;

  mixer_master u_master (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (sens_i[S_START]),
    .home_i      (sens_i[S_HOME]),
    .tank_done_i (tank_done),
    .trol_done_i (trol_done),
    .cont_done_i (cont_done),
    .branch_en_o (branch_en),
    .cont_en_o   (cont_en),
    .ret_o       (ret)
  );

  mixer_tank_fsm u_tank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (branch_en),
    .full_i  ({sens_i[S_FULL2], sens_i[S_FULL1]}),
    .ready_i ({sens_i[S_RDY2], sens_i[S_RDY1]}),
    .empty_i ({sens_i[S_EMPTY2], sens_i[S_EMPTY1]}),
    .mixed_i (sens_i[S_MIXED]),
    .inlet_o (inlet),
    .prep_o  (prep),
    .pour_o  (pour),
    .mix_o   (mix),
    .done_o  (tank_done)
  );

  mixer_trolley_fsm u_trolley (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (branch_en),
    .seated_i (sens_i[S_SEATED]),
    .end_i    (sens_i[S_END]),
    .deliv_o  (deliv),
    .move_o   (move),
    .done_o   (trol_done)
  );

  for (genvar gi = 0; gi < CONT_N; gi++) begin : g_cont
    mixer_cont_fsm u_cont (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (cont_en),
      .finished_i (sens_i[S_CDONE0+gi]),
      .fill_o     (cont_fill[gi]),
      .done_o     (cont_done[gi])
    );
  end

  always_comb begin
    act_o                            = '0;
    act_o[A_PREP1]                   = prep[0];
    act_o[A_PREP2]                   = prep[1];
    act_o[A_DELIV]                   = deliv;
    act_o[A_MIX]                     = mix;
    act_o[A_POUR1]                   = pour[0];
    act_o[A_POUR2]                   = pour[1];
    act_o[A_CFILL0 +: CONT_N]        = cont_fill;
    act_o[A_RET]                     = ret;
    act_o[A_INLET1]                  = inlet[0];
    act_o[A_INLET2]                  = inlet[1];
    act_o[A_TROL]                    = move;
  end
endmodule

// File: tb/mixer_ctrl_bench.sv
module mixer_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 23;

  localparam logic [12:0] X0 = 13'h0000, X1 = 13'h0001, X2 = 13'h0002, X3 = 13'h0004,
    X4 = 13'h0008, X5 = 13'h0010, X6 = 13'h0020, X7 = 13'h0040, X8 = 13'h0080,
    X9 = 13'h0100, X10 = 13'h0200, X11 = 13'h0400, X12 = 13'h0800, X13 = 13'h1000;
  localparam logic [11:0] Y0 = 12'h000, Y1 = 12'h001, Y2 = 12'h002, Y3 = 12'h004,
    Y4 = 12'h008, Y5 = 12'h010, Y6 = 12'h020, Y7 = 12'h040, Y8 = 12'h080,
    Y9 = 12'h100, Y10 = 12'h200, Y11 = 12'h400, Y12 = 12'h800;

  // each row: sensors held for one cycle, outputs expected after the edge
  localparam logic [12:0] V_S [NV] = '{
    X1,          // R2 start sampled
    X0,          // R2 branches launched
    X4,          // R4 seated -> trolley moves
    X5,          // R3 tank 1 full
    X1,          // R9 start ignored while running
    X7 | X13,    // R3 both full -> prep; R4 end reached
    X0,          // R5 prep held
    X3,          // R5 ingredient 2 ready
    X2,          // R5 both ready -> pour and mix
    X8,          // R6 tank 2 empty
    X6,          // R6 tank 1 empty
    X9,          // R6 mix tank empty -> branch done
    X0,          // R7 no container yet
    X0,          // R7 containers start together
    X10,         // R7 container 1 finished
    X0,          // R7 container 2 still running
    X11,         // R7 container 2 finished
    X0,          // R8 return starts
    X0,          // R8 return held
    X12,         // R8 home -> ready
    X1,          // R2 second batch start
    X5 | X7,     // R10 restart from first step, stale full sensors ignored
    X5 | X7      // R3 both full in one cycle
  };
  localparam logic [11:0] V_A [NV] = '{
    Y0,
    Y3 | Y10 | Y11,
    Y10 | Y11 | Y12,
    Y11 | Y12,
    Y11 | Y12,
    Y1 | Y2,
    Y1 | Y2,
    Y1,
    Y4 | Y5 | Y6,
    Y4 | Y5,
    Y4,
    Y0,
    Y0,
    Y7 | Y8,
    Y8,
    Y8,
    Y0,
    Y9,
    Y9,
    Y0,
    Y0,
    Y3 | Y10 | Y11,
    Y1 | Y2 | Y3
  };
  localparam int V_R [NV] = '{2, 2, 4, 3, 9, 3, 5, 5, 5, 6, 6, 6, 7, 7, 7, 7, 7, 8, 8, 8, 2, 10, 3};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [12:0] sens_i = '0;
  logic [11:0] act_o;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  mixer_ctrl u_mixer_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sens_i (sens_i),
    .act_o  (act_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  task automatic check(input logic [11:0] exp, input int req);
    n_chk++;
    if (act_o !== exp) begin
      n_fail++;
      $display("FAIL R%0d: act_o=%03h expected %03h at %0t", req, act_o, exp, $time);
    end
  endtask

  task automatic step(input logic [12:0] s, input logic [11:0] exp, input int req);
    sens_i = s;
    @(posedge clk_i);
    @(negedge clk_i);
    check(exp, req);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(Y0, 1); // R1 outputs low under reset
    rst_ni = 1'b1;
    step(X0, Y0, 1); // R1 ready and idle after release

    for (int i = 0; i < NV; i++) step(V_S[i], V_A[i], V_R[i]);

    // R1: asynchronous reset mid-batch clears outputs at once
    #1 rst_ni = 1'b0;
    #1 check(Y0, 1);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R9: sensors other than start do nothing in the ready state
    step(13'h1FFE, Y0, 9);
    step(X0, Y0, 9);
    step(X0, Y0, 9);

    // R2: start still accepted afterwards, home sensor not required
    step(X1, Y0, 2);
    step(X0, Y3 | Y10 | Y11, 2);

    // R4: seated and end in the same cycle only advance one step
    step(X4 | X13, Y10 | Y11 | Y12, 4);
    step(X0, Y10 | Y11 | Y12, 4);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule